// File: doc/BRIEF.md
# Packed Vector Attribute Loader

This block collects default vertex attribute vectors sent over a plain host write bus. A vector of four 24-bit floating-point components arrives as three 32-bit words. Any of three adjacent data addresses accepts a word, and the words are placed in the order they arrive. When the third word lands, the 96 bits are split into the four components and stored in one of sixteen attribute slots. The slot is chosen by an index register, which then steps to the next slot. This lets software stream a run of vectors into consecutive slots after a single index write.

A word-gathering state machine has three states. `ST_WORD0` waits for the first word and `ST_WORD1` waits for the second. `ST_WORD2` waits for the third word and commits the vector when it arrives. There are three transitions. A data write moves `ST_WORD0` to `ST_WORD1`, and another moves `ST_WORD1` to `ST_WORD2`. A data write in `ST_WORD2` commits and returns to `ST_WORD0`. A write to the index address forces a return to `ST_WORD0` from any state, which drops a partly gathered vector. A commit with an index of 16 or more stores nothing and sets a sticky error flag. A read port returns any stored vector without delay.

Top module: `vattr_loader`

## Requirements
- R1: After reset every slot reads as zero, the index reads 0 and the error flag reads 0.
- R2: A write to any of the three data addresses 0x233, 0x234 or 0x235 is placed in the next staging position in arrival order. The address within that group does not choose the position.
- R3: Take the three staged words d0, d1, d2 in arrival order. Component w is d0[31:8]. Component z is {d0[7:0], d1[31:16]}. Component y is {d1[15:0], d2[31:24]}. Component x is d2[23:0]. The read vector places w at bits 95:72, z at 71:48, y at 47:24 and x at 23:0.
- R4: A slot is written only at the third data write of a vector, and it becomes visible on the read port right after that clock edge. The first and second data writes change no slot.
- R5: A commit with an index below 16 writes the slot selected by the index, and the index then increases by one.
- R6: A commit with an index of 16 or more writes no slot, sets the error flag and leaves the index unchanged.
- R7: The error flag stays set until the index register is written.
- R8: A write to index address 0x232 loads the index from wr_data[4:0] and clears the error flag. It also returns gathering to the first word, so the words staged before it are discarded.
- R9: A write to any address outside 0x232 to 0x235 changes no staging state, slot, index or error flag.
- R10: rd_vec shows the contents of slot rd_slot combinationally, for any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 10 | Host write register address |
| wr_data | input | 32 | Host write data |
| rd_slot | input | 4 | Slot selected for reading |
| rd_vec | output | 96 | Stored vector {w,z,y,x} of the selected slot |
| idx_o | output | 5 | Current index register value |
| err_o | output | 1 | Sticky invalid-commit flag |

## Verification
The bench streams sixteen vectors through every slot and rotates the data address from word to word. A design that let the address pick the staging position would scramble the components. So would one that took the component bytes from the wrong side of a word boundary. Between words it reads the slots back, which catches a commit that happens one word early or a slot left unchanged by the third word. It then commits at index 16 to catch an index that still increments, or a write that wraps into slot 0. It checks that the error flag survives a stray write and clears on an index write. Finally it abandons a half-gathered vector with an index write, which catches stale words that leak into the next vector.

// File: rtl/vattr_pkg.sv
package vattr_pkg;
    localparam int WORD_W   = 32;
    localparam int COMP_W   = 24;
    localparam int NUM_COMP = 4;
    localparam int VEC_W    = COMP_W * NUM_COMP;
    localparam int NUM_WORD = VEC_W / WORD_W;

    // Word-gathering states: one per expected word of a vector
    typedef enum logic [1:0] {
        ST_WORD0 = 2'd0,
        ST_WORD1 = 2'd1,
        ST_WORD2 = 2'd2
    } gather_e;

    // Component order within the stored vector, most significant first
    typedef struct packed {
        logic [COMP_W-1:0] w;
        logic [COMP_W-1:0] z;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] x;
    } vec_t;
endpackage

// File: rtl/vattr_gather.sv
module vattr_gather
    import vattr_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_BASE  = 'h233,
    parameter int INDEX_ADDR = 'h232
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              data_hit,
    output logic              idx_hit,
    output logic              commit,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] word2
);
    localparam int GROUP = NUM_WORD;

    gather_e           state_q, state_d;
    logic [WORD_W-1:0] hold0_q, hold1_q;
    logic [GROUP-1:0]  addr_match;

    // One comparator per data address of the group
    genvar g;
    generate
        for (g = 0; g < GROUP; g++) begin : g_match
            assign addr_match[g] = (wr_addr == ADDR_W'(DATA_BASE + g));
        end
    endgenerate

    assign data_hit = wr_en && (|addr_match);
    assign idx_hit  = wr_en && (wr_addr == ADDR_W'(INDEX_ADDR));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WORD0;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (idx_hit) begin
            state_d = ST_WORD0;
        end else if (data_hit) begin
            unique case (state_q)
                ST_WORD0: state_d = ST_WORD1;
                ST_WORD1: state_d = ST_WORD2;
                ST_WORD2: state_d = ST_WORD0;
                default:  state_d = ST_WORD0;
            endcase
        end
    end

    // Staging buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold0_q <= '0;
            hold1_q <= '0;
        end else if (data_hit && !idx_hit) begin
            unique case (state_q)
                ST_WORD0: hold0_q <= wr_data;
                ST_WORD1: hold1_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_WORD0: commit = 1'b0;
            ST_WORD1: commit = 1'b0;
            ST_WORD2: commit = data_hit && !idx_hit;
            default:  commit = 1'b0;
        endcase
        word0 = hold0_q;
        word1 = hold1_q;
        word2 = wr_data;
    end
endmodule

// File: rtl/vattr_unpack.sv
module vattr_unpack
    import vattr_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output vec_t              vec
);
    logic [VEC_W-1:0]  stream;
    logic [COMP_W-1:0] comp [NUM_COMP];

    // Earliest word occupies the top of the bit stream
    assign stream = {word0, word1, word2};

    // Slice the stream into components, x from the bottom up to w at the top
    genvar c;
    generate
        for (c = 0; c < NUM_COMP; c++) begin : g_comp
            assign comp[c] = stream[c*COMP_W +: COMP_W];
        end
    endgenerate

    assign vec.x = comp[0];
    assign vec.y = comp[1];
    assign vec.z = comp[2];
    assign vec.w = comp[3];
endmodule

// File: rtl/vattr_slots.sv
module vattr_slots
    import vattr_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int IDX_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  vec_t                     vec,
    input  logic                     idx_wr,
    input  logic [IDX_W-1:0]         idx_val,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic [VEC_W-1:0]         rd_vec,
    output logic [IDX_W-1:0]         idx,
    output logic                     err
);
    localparam int SEL_W = $clog2(SLOTS);

    logic [VEC_W-1:0] mem [SLOTS];
    logic             idx_ok;

    assign idx_ok = (idx < IDX_W'(SLOTS));

    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[s] <= '0;
                else if (commit && idx_ok && (idx[SEL_W-1:0] == SEL_W'(s)))
                    mem[s] <= vec;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            err <= 1'b0;
        end else if (idx_wr) begin
            idx <= idx_val;
            err <= 1'b0;
        end else if (commit) begin
            if (idx_ok) idx <= idx + 1'b1;
            else        err <= 1'b1;
        end
    end

    assign rd_vec = mem[rd_slot];
endmodule

// File: rtl/vattr_loader.sv
module vattr_loader
    import vattr_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_BASE  = 'h233,
    parameter int INDEX_ADDR = 'h232,
    parameter int SLOTS      = 16,
    parameter int IDX_W      = $clog2(SLOTS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic [95:0]              rd_vec,
    output logic [IDX_W-1:0]         idx_o,
    output logic                     err_o
);
    logic              data_hit_w, idx_hit_w, commit_w;
    logic [WORD_W-1:0] w0, w1, w2;
    vec_t              vec_w;

    vattr_gather #(
        .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE), .INDEX_ADDR(INDEX_ADDR)
    ) u_gather (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .data_hit(data_hit_w), .idx_hit(idx_hit_w),
        .commit(commit_w), .word0(w0), .word1(w1), .word2(w2)
    );

    vattr_unpack u_unpack (
        .word0(w0), .word1(w1), .word2(w2), .vec(vec_w)
    );

    vattr_slots #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .commit(commit_w), .vec(vec_w),
        .idx_wr(idx_hit_w), .idx_val(wr_data[IDX_W-1:0]), .rd_slot(rd_slot),
        .rd_vec(rd_vec), .idx(idx_o), .err(err_o)
    );
endmodule

// File: rtl/vattr_loader_chk.sv
module vattr_loader_chk #(
    parameter int SLOTS = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit,
    input logic             data_hit,
    input logic             idx_wr,
    input logic [IDX_W-1:0] idx_val,
    input logic [IDX_W-1:0] idx,
    input logic             err
);
    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !idx_wr && idx < IDX_W'(SLOTS)) |=> (idx == $past(idx) + 1'b1));

    assert_bad_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !idx_wr && idx >= IDX_W'(SLOTS)) |=> (err && $stable(idx)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !idx_wr) |=> err);

    assert_idx_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (!err && idx == $past(idx_val)));

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_hit && !idx_wr) |=> ($stable(idx) && $stable(err)));

    assert_no_early_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> data_hit);
endmodule

bind vattr_loader vattr_loader_chk #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .data_hit(data_hit_w),
    .idx_wr(idx_hit_w), .idx_val(wr_data[IDX_W-1:0]), .idx(idx_o), .err(err_o)
);

// File: tb/tb_vattr_loader.sv
module tb_vattr_loader;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_slot = '0;
    logic [95:0] rd_vec;
    logic [4:0]  idx_o;
    logic        err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [95:0] exp_mem [SLOTS];

    vattr_loader dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_slot(rd_slot), .rd_vec(rd_vec),
        .idx_o(idx_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [95:0] pack_exp(input logic [31:0] d0, d1, d2);
        logic [23:0] w, z, y, x;
        w = 24'(d0 >> 8);
        z = 24'(((d0 & 32'hFF) << 16) | (d1 >> 16));
        y = 24'(((d1 & 32'hFFFF) << 8) | (d2 >> 24));
        x = 24'(d2 & 32'hFF_FFFF);
        return {w, z, y, x};
    endfunction

    function automatic logic [31:0] pat(input int n);
        return 32'h9E37_79B9 * 32'(n + 1) ^ 32'(n << 20);
    endfunction

    task automatic chk(input string req, input logic [95:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < SLOTS; s++) begin
            rd_slot = 4'(s); #1;
            chk(req, rd_vec, exp_mem[s]);
        end
    endtask

    initial begin
        for (int s = 0; s < SLOTS; s++) exp_mem[s] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        chk("R1 idx", 96'(idx_o), 96'd0);
        chk("R1 err", 96'(err_o), 96'd0);
        check_all("R1 slot");

        // R2/R3/R4/R5: sweep every slot, rotating the data address per word
        wr(10'h232, 32'd0);
        for (int v = 0; v < SLOTS; v++) begin
            logic [31:0] d [3];
            for (int k = 0; k < 3; k++) d[k] = pat(v*3 + k);
            for (int k = 0; k < 3; k++) begin
                wr(10'h233 + 10'((v + 2*k) % 3), d[k]);
                if (k < 2) begin
                    rd_slot = 4'(v); #1;
                    chk("R4 no early write", rd_vec, exp_mem[v]);
                    chk("R4 idx hold", 96'(idx_o), 96'(v));
                end
            end
            exp_mem[v] = pack_exp(d[0], d[1], d[2]);
            rd_slot = 4'(v); #1;
            chk("R3 w", 96'(rd_vec[95:72]), 96'(d[0] >> 8));
            chk("R3 x", 96'(rd_vec[23:0]), 96'(d[2] & 32'hFF_FFFF));
            chk("R2 R3 vector", rd_vec, exp_mem[v]);
            chk("R5 idx step", 96'(idx_o), 96'(v + 1));
        end
        check_all("R10 readback");

        // R6: commit at index 16
        wr(10'h234, 32'h1111_1111);
        wr(10'h233, 32'h2222_2222);
        wr(10'h235, 32'h3333_3333);
        chk("R6 err set", 96'(err_o), 96'd1);
        chk("R6 idx hold", 96'(idx_o), 96'd16);
        check_all("R6 no slot write");

        // R9/R7: stray writes touch nothing, err stays set
        wr(10'h231, 32'hFFFF_FFFF);
        wr(10'h236, 32'hFFFF_FFFF);
        wr(10'h033, 32'hFFFF_FFFF);
        chk("R7 err sticky", 96'(err_o), 96'd1);
        chk("R9 idx", 96'(idx_o), 96'd16);
        check_all("R9 slots");

        // R8: index write clears err, discards partial vector
        wr(10'h232, 32'hFFFF_FFE3);
        chk("R8 err clear", 96'(err_o), 96'd0);
        chk("R8 idx load", 96'(idx_o), 96'd3);
        wr(10'h233, 32'hDEAD_BEEF);
        wr(10'h235, 32'hCAFE_F00D);
        wr(10'h232, 32'd5);
        chk("R8 idx reload", 96'(idx_o), 96'd5);
        wr(10'h235, 32'hA5A5_0101);
        wr(10'h236, 32'h0); // R9 stray write between words
        wr(10'h234, 32'h5A5A_0202);
        wr(10'h233, 32'h0F0F_0303);
        exp_mem[5] = pack_exp(32'hA5A5_0101, 32'h5A5A_0202, 32'h0F0F_0303);
        check_all("R8 discard");
        chk("R8 idx after", 96'(idx_o), 96'd6);

        // R9: a stray write in the middle of a vector must not count as a word
        wr(10'h233, 32'h0102_0304);
        wr(10'h3FF, 32'hEEEE_EEEE);
        wr(10'h234, 32'h0506_0708);
        rd_slot = 4'd6; #1;
        chk("R9 no count", rd_vec, exp_mem[6]);
        wr(10'h235, 32'h090A_0B0C);
        exp_mem[6] = pack_exp(32'h0102_0304, 32'h0506_0708, 32'h090A_0B0C);
        check_all("R9 final");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule